// File: doc/BRIEF.md
# EPP Capture FIFO Read Port

This block holds a 2048-entry, 9-bit capture FIFO and exposes its read side to a host over an EPP-style parallel port. A sample source pushes entries on the write side. The host pulls them one at a time with data-read strobes. Each read strobe pops the oldest entry and drives it onto the 8-bit data bus. The ninth bit appears on a separate status line. A wait handshake follows the read strobe after a short delay, so the host latches data only once it is stable. An empty flag on a status line lets software poll for new data.

The host write line carries no data. Holding it low is a "next block" command: it clears the FIFO and advances a block-request counter that tells the capture side which group of four lines to collect next. Read and sample-write activity are both suppressed while the clear is active. One block of 4 lines by 512 samples fills the storage exactly. All host lines are taken as synchronous to `clk`.

Top module: `epp_capture_port`

## Requirements
- R1: While `host_strobe_n` is 0 and `host_write_n` is 1 at a clock edge, `bus_oe` is 1 in the following cycle.
- R2: While `host_strobe_n` is 1 or `host_write_n` is 0 at a clock edge, `bus_oe` is 0 in the following cycle.
- R3: Reads return entries in the order they were written. Bits 7:0 of an entry appear on `bus_out` and bit 8 appears on `host_aux`, both valid while `bus_oe` is 1.
- R4: `host_wait` (active high, meaning data is valid) rises two cycles after `bus_oe` rises and falls two cycles after `bus_oe` falls.
- R5: `host_empty` is 1 exactly when the FIFO holds no entry. It goes low in the cycle after the first accepted push.
- R6: While `host_write_n` is 0, the FIFO is cleared: `host_empty` is 1 from the next cycle, and sample pushes offered during the clear are discarded.
- R7: `block_req` increments by one, wrapping modulo 2^8, once for each 1-to-0 transition of `host_write_n`. It is otherwise unchanged.
- R8: When the FIFO holds 2048 entries, further pushes are ignored, and the first 2048 entries are read back intact.
- R9: A read while the FIFO is empty drives 0 on `bus_out` and `host_aux` and leaves the pointers unchanged. A later push is then read back correctly.
- R10: After reset, `bus_oe` and `host_wait` are 0, `host_empty` is 1 and `block_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_strobe_n | input | 1 | Host data strobe, active low |
| host_write_n | input | 1 | Host write line; low means the next-block command |
| wr_en | input | 1 | Sample push request |
| wr_data | input | 9 | Sample entry to push |
| bus_out | output | 8 | Read data toward the host bus |
| bus_oe | output | 1 | Bus driver enable; the bus is high-impedance when 0 |
| host_aux | output | 1 | Ninth bit of the entry being read |
| host_wait | output | 1 | Handshake: read data is valid |
| host_empty | output | 1 | FIFO empty status |
| block_req | output | 8 | Requested capture block number |

## Verification
The assertions assume that the host strobe and write lines are already synchronous to `clk` and change only between edges. They also assume the host never runs a read and a clear in the same cycle for any purpose other than the clear itself. The bench honours both assumptions by driving every input on the falling clock edge, and it returns the strobe high between reads for long enough that `host_wait` drops before the next read starts. The bench holds `host_write_n` low for whole cycles only, so each command gives exactly one falling transition.

// File: rtl/epp_cap_pkg.sv
package epp_cap_pkg;

    localparam int BUS_W    = 8;
    localparam int ENTRY_W  = BUS_W + 1;
    localparam int DEPTH    = 2048;          // power of two: pointers wrap naturally
    localparam int BLK_W    = 8;
    localparam int WAIT_DLY = 2;             // cycles from bus enable to wait

    typedef struct packed {
        logic             aux;
        logic [BUS_W-1:0] pix;
    } entry_t;

    function automatic logic [BLK_W-1:0] blk_next(input logic [BLK_W-1:0] cur);
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/epp_cap_fifo.sv
module epp_cap_fifo
    import epp_cap_pkg::*;
#(
    parameter int N_ENTRY = DEPTH,
    localparam int AW     = $clog2(N_ENTRY)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push_req,
    input  entry_t        push_data,
    input  logic          pop_req,
    output entry_t        rd_entry,
    output logic          empty,
    output logic [AW:0]   fill
);

    localparam logic [AW:0] FULL_CNT = (AW+1)'(N_ENTRY);

    entry_t          mem [N_ENTRY];
    logic [AW-1:0]   wptr, rptr;
    logic [AW:0]     cnt;
    logic            full, push, pop;

    assign empty = (cnt == '0);
    assign full  = (cnt == FULL_CNT);
    assign push  = push_req && !full && !clr;
    assign pop   = pop_req && !empty && !clr;
    assign fill  = cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // read register: oldest entry captured at the start of a read, zero if empty
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_entry <= '0;
        end else if (pop_req && !clr) begin
            rd_entry <= empty ? entry_t'('0) : mem[rptr];
        end
    end

endmodule

// File: rtl/epp_cap_handshake.sv
module epp_cap_handshake
    import epp_cap_pkg::*;
#(
    parameter int LAG = WAIT_DLY
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    input  logic write_n,
    output logic rd_start,
    output logic oe,
    output logic wait_ok
);

    logic           rd_cond;
    logic           rd_q;
    logic [LAG-1:0] lag_q;

    assign rd_cond  = !strobe_n && write_n;
    assign rd_start = rd_cond && !rd_q;
    assign oe       = rd_q;
    assign wait_ok  = lag_q[LAG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            lag_q <= '0;
        end else begin
            rd_q <= rd_cond;
            if (LAG == 1) lag_q <= LAG'(rd_q);
            else          lag_q <= LAG'({lag_q, rd_q});
        end
    end

endmodule

// File: rtl/epp_cap_blkcmd.sv
module epp_cap_blkcmd
    import epp_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             write_n,
    output logic             clr,
    output logic [BLK_W-1:0] blk
);

    logic write_n_q;

    assign clr = !write_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            write_n_q <= write_n;
            blk       <= '0;
        end else begin
            write_n_q <= write_n;
            if (write_n_q && !write_n) blk <= blk_next(blk);
        end
    end

endmodule

// File: rtl/epp_capture_port.sv
module epp_capture_port
    import epp_cap_pkg::*;
#(
    parameter int N_ENTRY = DEPTH,
    localparam int AW     = $clog2(N_ENTRY)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_strobe_n,
    input  logic               host_write_n,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [BUS_W-1:0]   bus_out,
    output logic               bus_oe,
    output logic               host_aux,
    output logic               host_wait,
    output logic               host_empty,
    output logic [BLK_W-1:0]   block_req
);

    logic        clr;
    logic        rd_start;
    entry_t      rd_entry;
    logic [AW:0] fill;

    epp_cap_blkcmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .write_n (host_write_n),
        .clr     (clr),
        .blk     (block_req)
    );

    epp_cap_handshake #(.LAG(WAIT_DLY)) u_hs (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (host_strobe_n),
        .write_n  (host_write_n),
        .rd_start (rd_start),
        .oe       (bus_oe),
        .wait_ok  (host_wait)
    );

    epp_cap_fifo #(.N_ENTRY(N_ENTRY)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push_req  (wr_en),
        .push_data (entry_t'(wr_data)),
        .pop_req   (rd_start),
        .rd_entry  (rd_entry),
        .empty     (host_empty),
        .fill      (fill)
    );

    assign bus_out  = rd_entry.pix;
    assign host_aux = rd_entry.aux;

endmodule

// File: rtl/epp_capture_port_chk.sv
module epp_capture_port_chk
    import epp_cap_pkg::*;
#(
    parameter int N_ENTRY = DEPTH,
    localparam int AW     = $clog2(N_ENTRY)
) (
    input logic             clk,
    input logic             rst,
    input logic             host_strobe_n,
    input logic             host_write_n,
    input logic             wr_en,
    input logic             bus_oe,
    input logic             host_wait,
    input logic             host_empty,
    input logic [BLK_W-1:0] block_req,
    input logic [AW:0]      fill
);

    localparam logic [AW:0] FULL_CNT = (AW+1)'(N_ENTRY);

    assert_read_enables_bus_R1: assert property (@(posedge clk) disable iff (rst)
        (!host_strobe_n && host_write_n) |=> bus_oe);

    assert_bus_released_R2: assert property (@(posedge clk) disable iff (rst)
        (host_strobe_n || !host_write_n) |=> !bus_oe);

    // wait lag fixed at two cycles (R4)
    assert_wait_not_early_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |=> !host_wait);

    assert_wait_follows_bus_R4: assert property (@(posedge clk) disable iff (rst)
        host_wait |-> $past(bus_oe, 2));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
        !host_write_n |=> (host_empty && fill == '0));

    assert_block_step_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(host_write_n) |=> block_req == blk_next($past(block_req)));

    assert_block_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$fell(host_write_n) |=> $stable(block_req));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (fill == FULL_CNT && host_write_n && host_strobe_n) |=> fill == FULL_CNT);

    assert_empty_read_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (host_empty && !wr_en) |=> host_empty);

endmodule

bind epp_capture_port epp_capture_port_chk #(.N_ENTRY(N_ENTRY)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_strobe_n (host_strobe_n),
    .host_write_n  (host_write_n),
    .wr_en         (wr_en),
    .bus_oe        (bus_oe),
    .host_wait     (host_wait),
    .host_empty    (host_empty),
    .block_req     (block_req),
    .fill          (fill)
);

// File: tb/epp_capture_port_tb.sv
module epp_capture_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_strobe_n = 1'b1;
    logic       host_write_n  = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [7:0] bus_out;
    logic       bus_oe, host_aux, host_wait, host_empty;
    logic [7:0] block_req;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    epp_capture_port u_dut (
        .clk           (clk),
        .rst           (rst),
        .host_strobe_n (host_strobe_n),
        .host_write_n  (host_write_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .bus_out       (bus_out),
        .bus_oe        (bus_oe),
        .host_aux      (host_aux),
        .host_wait     (host_wait),
        .host_empty    (host_empty),
        .block_req     (block_req)
    );

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) ^ (i >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [8:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic host_read(output logic [8:0] got, output logic oe);
        host_strobe_n = 1'b0;
        tick();
        got = {host_aux, bus_out};
        oe  = bus_oe;
        host_strobe_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic next_block();
        host_write_n = 1'b0;
        tick();
        host_write_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();   // R10
        chk(bus_oe == 1'b0,     "R10 bus_oe", int'(bus_oe), 0);
        chk(host_wait == 1'b0,  "R10 wait", int'(host_wait), 0);
        chk(host_empty == 1'b1, "R10 empty", int'(host_empty), 1);
        chk(block_req == 8'd0,  "R10 block_req", int'(block_req), 0);
    endtask

    task automatic t_order();   // R3, R5, R1
        logic [8:0] g; logic oe;
        push(pat(100));
        chk(host_empty == 1'b0, "R5 not empty after push", int'(host_empty), 0);
        for (int i = 101; i < 110; i++) push(pat(i));
        for (int i = 100; i < 110; i++) begin
            host_read(g, oe);
            chk(oe == 1'b1, "R1 bus enabled during read", int'(oe), 1);
            chk(g == pat(i), "R3 entry order/data", int'(g), int'(pat(i)));
        end
        chk(host_empty == 1'b1, "R5 empty after draining", int'(host_empty), 1);
    endtask

    task automatic t_wait();    // R4, R2
        push(9'h1A5);
        chk(bus_oe == 1'b0, "R2 bus idle", int'(bus_oe), 0);
        host_strobe_n = 1'b0;
        tick();
        chk(bus_oe == 1'b1,    "R1 bus on",           int'(bus_oe), 1);
        chk(host_wait == 1'b0, "R4 wait low +1",      int'(host_wait), 0);
        tick();
        chk(host_wait == 1'b0, "R4 wait low +2",      int'(host_wait), 0);
        tick();
        chk(host_wait == 1'b1, "R4 wait high +3",     int'(host_wait), 1);
        chk({host_aux, bus_out} == 9'h1A5, "R3 stable data", int'({host_aux, bus_out}), 'h1A5);
        host_strobe_n = 1'b1;
        tick();
        chk(bus_oe == 1'b0,    "R2 bus off after strobe", int'(bus_oe), 0);
        chk(host_wait == 1'b1, "R4 wait still high",      int'(host_wait), 1);
        tick();
        chk(host_wait == 1'b1, "R4 wait high +2 off",     int'(host_wait), 1);
        tick();
        chk(host_wait == 1'b0, "R4 wait low +3 off",      int'(host_wait), 0);
    endtask

    task automatic t_clear();   // R6, R7, R2
        logic [7:0] b0;
        for (int i = 0; i < 5; i++) push(pat(i));
        b0 = block_req;
        host_strobe_n = 1'b0;
        host_write_n  = 1'b0;
        wr_en = 1'b1; wr_data = 9'h0FF;
        tick();
        chk(bus_oe == 1'b0,     "R2 no drive while write low", int'(bus_oe), 0);
        chk(host_empty == 1'b1, "R6 cleared", int'(host_empty), 1);
        chk(block_req == b0 + 8'd1, "R7 block step", int'(block_req), int'(b0 + 8'd1));
        tick();
        chk(block_req == b0 + 8'd1, "R7 single step while held", int'(block_req), int'(b0 + 8'd1));
        wr_en = 1'b0; host_strobe_n = 1'b1; host_write_n = 1'b1;
        tick();
        chk(host_empty == 1'b1, "R6 pushes during clear discarded", int'(host_empty), 1);
    endtask

    task automatic t_wrap();    // R7
        logic [7:0] exp;
        exp = block_req;
        for (int i = 0; i < 300; i++) begin
            next_block();
            exp = exp + 8'd1;
        end
        chk(block_req == exp, "R7 wraps modulo 256", int'(block_req), int'(exp));
    endtask

    task automatic t_empty_read();  // R9
        logic [8:0] g; logic oe;
        host_read(g, oe);
        chk(g == 9'd0, "R9 empty read returns zero", int'(g), 0);
        chk(host_empty == 1'b1, "R9 still empty", int'(host_empty), 1);
        push(9'h155);
        host_read(g, oe);
        chk(g == 9'h155, "R9 pointer kept", int'(g), 'h155);
    endtask

    task automatic t_full();    // R8
        logic [8:0] g; logic oe;
        int bad = 0;
        next_block();
        for (int i = 0; i <= 2048; i++) push(pat(i + 7));
        for (int i = 0; i < 2048; i++) begin
            host_read(g, oe);
            if (g != pat(i + 7)) begin
                if (bad == 0) chk(1'b0, "R8 full readback", int'(g), int'(pat(i + 7)));
                bad++;
            end
        end
        chk(bad == 0, "R8 all 2048 entries intact", bad, 0);
        chk(host_empty == 1'b1, "R8 extra push ignored", int'(host_empty), 1);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_order();
        t_wait();
        t_clear();
        t_wrap();
        t_empty_read();
        t_full();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

endmodule